// File: doc/BRIEF.md
# Effective Bandwidth Metric Unit

This block turns raw per-application memory counters into a utility score for two applications sharing a GPU memory system. For each application it forms the attained DRAM bandwidth (useful bytes over the peak bytes the window allows) and a combined miss rate (the L1 miss rate times the L2 miss rate). The score, called effective bandwidth, is the attained bandwidth divided by the combined miss rate. A lower miss rate therefore multiplies the delivered bandwidth: a 50% combined miss rate doubles it.

From the two scores the unit derives three combined metrics: a throughput metric (plain sum of the unscaled scores), a fairness metric (smaller score over larger score, so 1.0 means perfectly balanced) and a harmonic metric (product over sum, which equals 1/(1/a + 1/b)). Before fairness and harmonic are formed, each score may be divided by a per-application alone-run scale factor. All rates are unsigned Q8.16. One restoring divider, shared by every quotient and producing one quotient bit per cycle, does all the division work. It is sequenced by a four-state machine: `ST_IDLE` waits for `start` and captures the inputs; `ST_ISSUE` launches the current division; `ST_WAIT` holds until the divider finishes, writes the result and either advances to the next operation (back to `ST_ISSUE`) or, after the last one, moves to `ST_DONE`; `ST_DONE` presents all outputs with a one-cycle `done` and returns to `ST_IDLE`. The twelve operations run in a fixed order: two bandwidths, four miss rates, two scores, two scaled scores, fairness, harmonic.

Software or a controller samples the counters at the end of each window, pulses `start`, and reads the five results when `done` rises.

Top module: `ebm_unit`

## Requirements
- R1: Attained bandwidth per application is floor(bytes*2^16/peak) in Q8.16; with both miss rates equal to 1.0 (miss count equal to access count), the score equals this bandwidth.
- R2: Each miss rate is floor(miss*2^16/access). The combined miss rate is floor(l1_rate*l2_rate/2^16), and the score is floor(bandwidth*2^16/combined_rate).
- R3: If any of an application's four miss or access counts is zero, or the combined rate rounds to zero, the combined rate is forced to 1 LSB (0x000001), so no division by zero occurs.
- R4: Every quotient that exceeds 0xFFFFFF, including any division by zero, saturates to 0xFFFFFF.
- R5: `ws` equals eb[0]+eb[1] computed from the unscaled scores, saturated to 0xFFFFFF.
- R6: `fi` equals floor(min(s0,s1)*2^16/max(s0,s1)) of the scaled scores s0,s1. It never exceeds 0x010000, and it is exactly 0x010000 when both scaled scores are zero.
- R7: `hs` equals floor(s0*s1/(s0+s1)) of the scaled scores, and it is 0 when both are zero.
- R8: Scaled score si = floor(eb[i]*2^16/scale[i]). A scale of 0 means no scaling (si = eb[i]).
- R9: `done` is high for exactly one cycle per computation; at that cycle all outputs carry the new results and they hold until the next `done`.
- R10: A `start` pulse that arrives while a computation is in progress is ignored: it yields no extra `done` and no change to the results being computed.
- R11: After reset all outputs are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted only in ST_IDLE) |
| peak_bytes | input | 32 | Peak DRAM bytes per window |
| app_bytes | input | 2x32 | Useful DRAM bytes, per application |
| l1_acc | input | 2x32 | L1 accesses, per application |
| l1_miss | input | 2x32 | L1 misses, per application |
| l2_acc | input | 2x32 | L2 accesses, per application |
| l2_miss | input | 2x32 | L2 misses, per application |
| scale | input | 2x24 | Alone-run scale factor, Q8.16, 0 = none |
| eb | output | 2x24 | Effective bandwidth scores, Q8.16 |
| ws | output | 24 | Throughput metric (sum) |
| fi | output | 24 | Fairness metric (min ratio) |
| hs | output | 24 | Harmonic metric |
| done | output | 1 | One-cycle results-valid strobe |

## Verification
Every cycle the assertions check the following:
- `done` never lasts two cycles.
- At `done`, fairness is at most 1.0, the sum is no smaller than either score, and the harmonic value is no larger than the smaller scaled score.
- Captured inputs stay frozen while the machine is busy.
- The combined miss rate is never zero during a division.
- The divider leaves a remainder below its divisor, and saturates when the divisor is zero.

Only the bench scenarios can show the following:
- Exact values for the main cases: normalisation, the miss-rate product, the zero-count floor, saturation, scaling, and the all-zero fairness and harmonic cases.
- That a mid-run `start` produces neither an extra result nor a corrupted one.

// File: rtl/ebm_pkg.sv
`timescale 1ns/1ps
package ebm_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} ebm_state_e;
    typedef enum logic [3:0] {
        OP_BW0, OP_BW1, OP_M1A, OP_M2A, OP_M1B, OP_M2B,
        OP_EB0, OP_EB1, OP_SC0, OP_SC1, OP_FI,  OP_HS
    } ebm_op_e;
endpackage

// File: rtl/ebm_sdiv.sv
`timescale 1ns/1ps
module ebm_sdiv #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 32,
    parameter int Q_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic             run;
    logic [CW-1:0]    cnt;
    logic [NUM_W-1:0] q;
    logic [DEN_W:0]   rem;
    logic [DEN_W-1:0] d;
    logic [DEN_W:0]   rem_sh;
    logic             fits;

    always_comb begin
        rem_sh = {rem[DEN_W-1:0], q[NUM_W-1]};
        fits   = (rem_sh >= {1'b0, d});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            cnt  <= '0;
            q    <= '0;
            rem  <= '0;
            d    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                run <= 1'b1;
                cnt <= CW'(NUM_W);
                q   <= num;
                rem <= '0;
                d   <= den;
            end else if (run) begin
                rem <= fits ? (rem_sh - {1'b0, d}) : rem_sh;
                q   <= {q[NUM_W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = (|q[NUM_W-1:Q_W]) ? '1 : q[Q_W-1:0];

    // R2
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && d != '0) |-> (rem < {1'b0, d}));
    // R4
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && d == '0) |-> (quo == '1));
endmodule

// File: rtl/ebm_cmr.sv
`timescale 1ns/1ps
module ebm_cmr #(
    parameter int Q_W  = 24,
    parameter int FRAC = 16
) (
    input  logic [Q_W-1:0] rate_a,
    input  logic [Q_W-1:0] rate_b,
    input  logic           force_min,
    output logic [Q_W-1:0] cmr
);
    localparam int PW = 2 * Q_W;

    logic [PW-1:0] prod;
    logic [PW-1:0] hi;
    logic [Q_W-1:0] clip;

    always_comb begin
        prod = PW'(rate_a) * PW'(rate_b);
        hi   = prod >> FRAC;
        clip = (|hi[PW-1:Q_W]) ? '1 : hi[Q_W-1:0];
        if (force_min || clip == '0) cmr = Q_W'(1);
        else                         cmr = clip;
    end
endmodule

// File: rtl/ebm_unit.sv
`timescale 1ns/1ps
module ebm_unit
    import ebm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int Q_W   = 24,
    parameter int FRAC  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CNT_W-1:0]          peak_bytes,
    input  logic [1:0][CNT_W-1:0]     app_bytes,
    input  logic [1:0][CNT_W-1:0]     l1_acc,
    input  logic [1:0][CNT_W-1:0]     l1_miss,
    input  logic [1:0][CNT_W-1:0]     l2_acc,
    input  logic [1:0][CNT_W-1:0]     l2_miss,
    input  logic [1:0][Q_W-1:0]       scale,
    output logic [1:0][Q_W-1:0]       eb,
    output logic [Q_W-1:0]            ws,
    output logic [Q_W-1:0]            fi,
    output logic [Q_W-1:0]            hs,
    output logic                      done
);
    localparam int NUM_W = (2 * Q_W > CNT_W + FRAC) ? 2 * Q_W : CNT_W + FRAC;
    localparam int DEN_W = CNT_W;
    localparam logic [Q_W-1:0] ONE = Q_W'(1) << FRAC;

    ebm_state_e st, st_nx;
    ebm_op_e    op;

    logic [CNT_W-1:0]      cap_peak;
    logic [1:0][CNT_W-1:0] cap_bytes, cap_l1a, cap_l1m, cap_l2a, cap_l2m;
    logic [1:0][Q_W-1:0]   cap_scale;
    logic [1:0][Q_W-1:0]   bw, m1, m2, ebr, sc, cmr;
    logic [1:0]            zflag;
    logic [Q_W-1:0]        fi_r;

    logic [NUM_W-1:0] d_num;
    logic [DEN_W-1:0] d_den;
    logic             d_done;
    logic [Q_W-1:0]   d_quo;

    logic [Q_W-1:0]   mn, mx;
    logic [Q_W:0]     ssum, esum;
    logic [2*Q_W-1:0] sprod;

    for (genvar i = 0; i < 2; i++) begin : g_app
        assign zflag[i] = (cap_l1a[i] == '0) || (cap_l1m[i] == '0) ||
                          (cap_l2a[i] == '0) || (cap_l2m[i] == '0);
        ebm_cmr #(.Q_W(Q_W), .FRAC(FRAC)) i_cmr (
            .rate_a(m1[i]), .rate_b(m2[i]), .force_min(zflag[i]), .cmr(cmr[i]));
    end

    ebm_sdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(Q_W)) i_div (
        .clk(clk), .rst_n(rst_n), .start(st == ST_ISSUE),
        .num(d_num), .den(d_den), .done(d_done), .quo(d_quo));

    always_comb begin
        mn    = (sc[0] < sc[1]) ? sc[0] : sc[1];
        mx    = (sc[0] < sc[1]) ? sc[1] : sc[0];
        ssum  = {1'b0, sc[0]} + {1'b0, sc[1]};
        esum  = {1'b0, ebr[0]} + {1'b0, ebr[1]};
        sprod = (2*Q_W)'(sc[0]) * (2*Q_W)'(sc[1]);
        d_num = '0;
        d_den = '0;
        unique case (op)
            OP_BW0: begin d_num = NUM_W'(cap_bytes[0]) << FRAC; d_den = cap_peak; end
            OP_BW1: begin d_num = NUM_W'(cap_bytes[1]) << FRAC; d_den = cap_peak; end
            OP_M1A: begin d_num = NUM_W'(cap_l1m[0]) << FRAC;   d_den = cap_l1a[0]; end
            OP_M2A: begin d_num = NUM_W'(cap_l2m[0]) << FRAC;   d_den = cap_l2a[0]; end
            OP_M1B: begin d_num = NUM_W'(cap_l1m[1]) << FRAC;   d_den = cap_l1a[1]; end
            OP_M2B: begin d_num = NUM_W'(cap_l2m[1]) << FRAC;   d_den = cap_l2a[1]; end
            OP_EB0: begin d_num = NUM_W'(bw[0]) << FRAC;        d_den = DEN_W'(cmr[0]); end
            OP_EB1: begin d_num = NUM_W'(bw[1]) << FRAC;        d_den = DEN_W'(cmr[1]); end
            OP_SC0: begin
                d_num = NUM_W'(ebr[0]) << FRAC;
                d_den = (cap_scale[0] == '0) ? DEN_W'(ONE) : DEN_W'(cap_scale[0]);
            end
            OP_SC1: begin
                d_num = NUM_W'(ebr[1]) << FRAC;
                d_den = (cap_scale[1] == '0) ? DEN_W'(ONE) : DEN_W'(cap_scale[1]);
            end
            OP_FI: begin
                d_num = (mx == '0) ? (NUM_W'(ONE) << FRAC) : (NUM_W'(mn) << FRAC);
                d_den = (mx == '0) ? DEN_W'(ONE) : DEN_W'(mx);
            end
            OP_HS: begin
                d_num = NUM_W'(sprod);
                d_den = (ssum == '0) ? DEN_W'(1) : DEN_W'(ssum);
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_ISSUE;
            ST_ISSUE: st_nx = ST_WAIT;
            ST_WAIT:  if (d_done) st_nx = (op == OP_HS) ? ST_DONE : ST_ISSUE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op <= OP_BW0;
            cap_peak <= '0; cap_bytes <= '0; cap_l1a <= '0; cap_l1m <= '0;
            cap_l2a <= '0; cap_l2m <= '0; cap_scale <= '0;
            bw <= '0; m1 <= '0; m2 <= '0; ebr <= '0; sc <= '0; fi_r <= '0;
            eb <= '0; ws <= '0; fi <= '0; hs <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                op        <= OP_BW0;
                cap_peak  <= peak_bytes;
                cap_bytes <= app_bytes;
                cap_l1a   <= l1_acc;
                cap_l1m   <= l1_miss;
                cap_l2a   <= l2_acc;
                cap_l2m   <= l2_miss;
                cap_scale <= scale;
            end
            if (st == ST_WAIT && d_done) begin
                unique case (op)
                    OP_BW0: bw[0]  <= d_quo;
                    OP_BW1: bw[1]  <= d_quo;
                    OP_M1A: m1[0]  <= d_quo;
                    OP_M2A: m2[0]  <= d_quo;
                    OP_M1B: m1[1]  <= d_quo;
                    OP_M2B: m2[1]  <= d_quo;
                    OP_EB0: ebr[0] <= d_quo;
                    OP_EB1: ebr[1] <= d_quo;
                    OP_SC0: sc[0]  <= d_quo;
                    OP_SC1: sc[1]  <= d_quo;
                    OP_FI:  fi_r   <= d_quo;
                    OP_HS: begin
                        hs <= d_quo;
                        fi <= fi_r;
                        eb <= ebr;
                        ws <= esum[Q_W] ? '1 : esum[Q_W-1:0];
                    end
                    default: ;
                endcase
                if (op != OP_HS) op <= ebm_op_e'(op + 4'd1);
            end
        end
    end

    assign done = (st == ST_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    fi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fi <= ONE));
    // R5
    ws_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ws >= eb[0] && ws >= eb[1]));
    // R7
    hs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hs <= mn));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(cap_peak) && $stable(cap_bytes) && $stable(cap_scale)));
    // R3
    cmr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (cmr[0] != '0 && cmr[1] != '0));
endmodule

// File: tb/test_ebm_unit.sv
`timescale 1ns/1ps
module test_ebm_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0]      peak;
    logic [1:0][31:0] bytes, l1a, l1m, l2a, l2m;
    logic [1:0][23:0] scale;
    logic [1:0][23:0] eb;
    logic [23:0]      ws, fi, hs;
    logic             done;

    always #2 clk = ~clk;

    ebm_unit i_ebm_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .peak_bytes(peak),
        .app_bytes(bytes), .l1_acc(l1a), .l1_miss(l1m), .l2_acc(l2a), .l2_miss(l2m),
        .scale(scale), .eb(eb), .ws(ws), .fi(fi), .hs(hs), .done(done));

    typedef struct {
        logic [23:0] eb0, eb1, ws, fi, hs;
        string       tag;
    } exp_t;

    exp_t q_exp[$];
    exp_t last;
    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    logic prev_done = 1'b0;
    bit finished = 0;

    task automatic chk(input logic [23:0] act, input logic [23:0] expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, expv);
        end
    endtask

    task automatic chk_bit(input logic act, input logic expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, expv);
        end
    endtask

    function automatic logic [23:0] divsat(input logic [63:0] n, input logic [63:0] d);
        logic [63:0] qv;
        if (d == 0) return 24'hFFFFFF;
        qv = n / d;
        return (qv > 64'hFFFFFF) ? 24'hFFFFFF : qv[23:0];
    endfunction

    // model built from the requirements
    function automatic exp_t predict(input string tag);
        exp_t e;
        logic [63:0] bw, r1, r2, p, cmr, s [2], v [2], mn, mx, sum;
        for (int i = 0; i < 2; i++) begin
            bw = divsat(64'(bytes[i]) << 16, 64'(peak));
            r1 = divsat(64'(l1m[i]) << 16, 64'(l1a[i]));
            r2 = divsat(64'(l2m[i]) << 16, 64'(l2a[i]));
            if (l1a[i] == 0 || l1m[i] == 0 || l2a[i] == 0 || l2m[i] == 0) cmr = 1;
            else begin
                p = (r1 * r2) >> 16;
                cmr = (p > 64'hFFFFFF) ? 64'hFFFFFF : p;
                if (cmr == 0) cmr = 1;
            end
            v[i] = divsat(bw << 16, cmr);
            s[i] = divsat(v[i] << 16, (scale[i] == 0) ? 64'h10000 : 64'(scale[i]));
        end
        e.eb0 = v[0][23:0];
        e.eb1 = v[1][23:0];
        sum = v[0] + v[1];
        e.ws = (sum > 64'hFFFFFF) ? 24'hFFFFFF : sum[23:0];
        mn = (s[0] < s[1]) ? s[0] : s[1];
        mx = (s[0] < s[1]) ? s[1] : s[0];
        e.fi = (mx == 0) ? 24'h010000 : divsat(mn << 16, mx);
        sum = s[0] + s[1];
        e.hs = (sum == 0) ? 24'h0 : divsat(s[0] * s[1], sum);
        e.tag = tag;
        return e;
    endfunction

    // monitor: pop and compare at each done
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done) chk_bit(done, 1'b0, "R9 done lasts one cycle");
            if (done) begin
                done_cnt++;
                if (q_exp.size() == 0) begin
                    chk_bit(1'b1, 1'b0, "R10 unexpected done");
                end else begin
                    last = q_exp.pop_front();
                    chk(eb[0], last.eb0, {last.tag, " eb0"});
                    chk(eb[1], last.eb1, {last.tag, " eb1"});
                    chk(ws, last.ws, "R5 ws");
                    chk(fi, last.fi, "R6 fi");
                    chk(hs, last.hs, "R7 hs");
                end
            end
            prev_done = done;
        end
    end

    task automatic set_app(input int i, input logic [31:0] b, input logic [31:0] a1,
                           input logic [31:0] x1, input logic [31:0] a2,
                           input logic [31:0] x2, input logic [23:0] sc);
        bytes[i] = b; l1a[i] = a1; l1m[i] = x1; l2a[i] = a2; l2m[i] = x2; scale[i] = sc;
    endtask

    task automatic run_case(input string tag);
        int target;
        q_exp.push_back(predict(tag));
        target = done_cnt + 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (done_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
        // R9: outputs held after done
        chk(ws, last.ws, "R9 ws held");
        chk(eb[0], last.eb0, "R9 eb0 held");
    endtask

    initial begin
        int target;
        peak = 0; bytes = '0; l1a = '0; l1m = '0; l2a = '0; l2m = '0; scale = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(eb[0], 24'h0, "R11 eb0 reset");
        chk(ws, 24'h0, "R11 ws reset");
        chk(fi, 24'h0, "R11 fi reset");
        chk(hs, 24'h0, "R11 hs reset");
        chk_bit(done, 1'b0, "R11 done reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: miss rates of 1.0 leave bandwidth unchanged
        peak = 4000;
        set_app(0, 1000, 100, 100, 50, 50, 0);
        set_app(1, 4000, 7, 7, 9, 9, 0);
        run_case("R1");

        // R2: miss-rate product amplifies bandwidth
        peak = 10000;
        set_app(0, 2500, 100, 50, 100, 25, 0);
        set_app(1, 3000, 300, 100, 64, 48, 0);
        run_case("R2");

        // R3: zero miss / zero access floor
        peak = 1000000;
        set_app(0, 3, 100, 0, 100, 10, 0);
        set_app(1, 0, 10, 5, 0, 3, 0);
        run_case("R3");

        // R3: tiny combined rate rounds to zero, still floored
        set_app(0, 1, 1000000, 1, 1000000, 1, 0);
        set_app(1, 500000, 10, 10, 10, 10, 0);
        run_case("R3");

        // R4: saturation of bandwidth and sum
        peak = 1;
        set_app(0, 32'hFFFFFFFF, 5, 5, 5, 5, 0);
        set_app(1, 32'h00FFFFFF, 5, 5, 5, 5, 0);
        run_case("R4");

        // R4: zero peak divides by zero
        peak = 0;
        set_app(0, 10, 5, 5, 5, 5, 0);
        set_app(1, 0, 5, 5, 5, 5, 0);
        run_case("R4");

        // R8: scale factors
        peak = 8000;
        set_app(0, 2000, 100, 40, 100, 60, 24'h020000);
        set_app(1, 1000, 100, 20, 100, 80, 24'h008000);
        run_case("R8");

        // R6/R7: both scores zero
        peak = 500;
        set_app(0, 0, 10, 5, 10, 5, 0);
        set_app(1, 0, 10, 5, 10, 5, 0);
        run_case("R6");

        // R10: start during busy is ignored
        peak = 6000;
        set_app(0, 1500, 200, 30, 90, 45, 24'h018000);
        set_app(1, 4500, 50, 40, 80, 20, 0);
        q_exp.push_back(predict("R10"));
        target = done_cnt + 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        peak = 77;
        set_app(0, 9, 3, 1, 3, 1, 24'h1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (done_cnt < target) @(negedge clk);
        repeat (1500) @(negedge clk);
        total++;
        if (done_cnt != target) begin
            bad++;
            $display("FAIL R10 done count: actual=%0d expected=%0d", done_cnt, target);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule